// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sits between a processor core and an on-chip flash array. It sequences the three self-programming operations: erasing a page, loading one word into the temporary page buffer, and writing the buffer to a page. Software first writes a command value to an 8-bit control register. That write arms the command for a short window. A separate execute strobe, which stands for the program-memory store instruction, must arrive inside that window. If it does not, the command is dropped.

An erase or a write lasts a fixed number of cycles. If the target page lies below a configurable boundary, it is in the region that can be read while another region is written. That region is then flagged busy, and the flag stays set until software writes a re-enable bit. If the page lies at or above the boundary, a CPU-halt output is held for the whole operation instead. A level interrupt request is raised whenever interrupts are enabled and no command is pending.

Top module: `selfprog_cmd_ctrl`

## Requirements
- R1: After reset, `ctlStatus` is 0, and `rwwBusy`, `cpuHalt`, `irqReq`, `bufWrEn` and `bufClear` are all low.
- R2: A control value whose bits [5:0] are 000011 selects page erase. The page is taken from `zAddr[ADDR_W-1:WORD_W]`. The word field and `wData` are ignored.
- R3: A control value whose bits [5:0] are 000001 selects buffer load. An accepted strobe gives a one-cycle `bufWrEn` in the next cycle, with `bufWrAddr` set to the word field of `zAddr` and `bufWrData` set to `wData`. The pending bit `ctlStatus[0]` clears at the same edge.
- R4: A control value whose bits [5:0] are 000101 selects page write. It runs like an erase, and when it completes it pulses `bufClear` for one cycle.
- R5: A control write with bit 0 set opens an arm window. A strobe sampled on any of the next ARM_WINDOW (4) clock edges is accepted. If no strobe arrives in that window, the pending bit clears and later strobes have no effect.
- R6: An erase or write to a page below NRWW_FIRST_PAGE sets `rwwBusy` (which is also `ctlStatus[6]`) and does not assert `cpuHalt`.
- R7: An erase or write to a page at or above NRWW_FIRST_PAGE holds `cpuHalt` high for exactly BUSY_CYCLES cycles. The pending bit stays set during that time and clears when `cpuHalt` falls.
- R8: `rwwBusy` stays set after its operation completes. It clears only on a control write with bit 4 set, and that write also pulses `bufClear` and arms nothing.
- R9: `irqReq` is high whenever the stored interrupt-enable bit (control bit 7, shown as `ctlStatus[7]`) is set and the pending bit is clear.
- R10: A control write restarts the arm window and takes priority over a strobe in the same cycle. Control writes made during an erase or write are ignored.
- R11: An accepted strobe with any other command code clears the pending bit and starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control register write enable |
| ctlWrData | input | 8 | Control register write value |
| execStrobe | input | 1 | Execute strobe (store-program-memory instruction) |
| zAddr | input | ADDR_W | Address: page field above word field |
| wData | input | 16 | Data word for buffer load |
| ctlStatus | output | 8 | {irq enable, busy flag, command bits [5:1], pending} |
| rwwBusy | output | 1 | Read-while-write region blocked |
| cpuHalt | output | 1 | Halt request while the other region is programmed |
| irqReq | output | 1 | Level interrupt request |
| bufWrEn | output | 1 | Temporary buffer write strobe |
| bufWrAddr | output | WORD_W | Buffer word index |
| bufWrData | output | 16 | Buffer write data |
| bufClear | output | 1 | Temporary buffer erase pulse |

## Verification
The control write and the execute strobe can land on the same clock edge. The register write has to win and reopen the window. The bench provokes this by raising both inputs together on the last edge of an open load window. It checks that no buffer write appears, then sends a lone strobe on the fourth edge of the new window and expects the load to be accepted. A re-enable write and a register write that arrives during an operation are also exercised, and both are judged through `ctlStatus`, `rwwBusy` and the count of buffer clear pulses.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
  typedef struct packed {
    logic loadWord;
    logic startOp;
    logic isWrite;
    logic opDone;
    logic reenable;
  } ctrl_strobe_t;

  localparam logic [5:0] CMD_LOAD  = 6'b000001;
  localparam logic [5:0] CMD_ERASE = 6'b000011;
  localparam logic [5:0] CMD_WRITE = 6'b000101;
  localparam int GO_BIT       = 0;
  localparam int REENABLE_BIT = 4;
  localparam int IE_BIT       = 7;
endpackage

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
  import selfprog_pkg::*;
#(
  parameter int BUSY_CYCLES = 20,
  parameter int ARM_WINDOW  = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctlWrEn,
  input  logic [7:0]   ctlWrData,
  input  logic         execStrobe,
  output ctrl_strobe_t strb,
  output logic         pending,
  output logic         irqEnable,
  output logic [5:1]   cmdHi
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int ARM_W  = $clog2(ARM_WINDOW + 1);

  logic [ARM_W-1:0]  armCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic              opBusy;
  logic              armed;
  logic              accept;
  logic [5:0]        cmdCode;
  logic              unusedCtlBit;

  assign unusedCtlBit = ctlWrData[6];
  assign cmdCode = {cmdHi, 1'b1};
  assign armed   = pending && (armCnt != '0) && !opBusy;
  assign accept  = armed && execStrobe && !ctlWrEn;

  always_comb begin
    strb          = '0;
    strb.loadWord = accept && (cmdCode == CMD_LOAD);
    strb.startOp  = accept && ((cmdCode == CMD_ERASE) || (cmdCode == CMD_WRITE));
    strb.isWrite  = (cmdCode == CMD_WRITE);
    strb.opDone   = opBusy && (busyCnt == BUSY_W'(1));
    strb.reenable = ctlWrEn && !opBusy && ctlWrData[REENABLE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armCnt    <= '0;
      busyCnt   <= '0;
      opBusy    <= 1'b0;
      pending   <= 1'b0;
      irqEnable <= 1'b0;
      cmdHi     <= '0;
    end else if (opBusy) begin
      busyCnt <= busyCnt - BUSY_W'(1);
      if (strb.opDone) begin
        opBusy  <= 1'b0;
        pending <= 1'b0;
      end
    end else if (ctlWrEn) begin
      irqEnable <= ctlWrData[IE_BIT];
      cmdHi     <= ctlWrData[5:1];
      if (ctlWrData[REENABLE_BIT] || !ctlWrData[GO_BIT]) begin
        pending <= 1'b0;
        armCnt  <= '0;
      end else begin
        pending <= 1'b1;
        armCnt  <= ARM_W'(ARM_WINDOW);
      end
    end else if (armed) begin
      if (execStrobe) begin
        armCnt <= '0;
        if (strb.startOp) begin
          opBusy  <= 1'b1;
          busyCnt <= BUSY_W'(BUSY_CYCLES);
        end else begin
          pending <= 1'b0;
        end
      end else begin
        armCnt <= armCnt - ARM_W'(1);
        if (armCnt == ARM_W'(1)) pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/selfprog_dpath.sv
module selfprog_dpath
  import selfprog_pkg::*;
#(
  parameter int PAGE_W          = 5,
  parameter int WORD_W          = 5,
  parameter int NRWW_FIRST_PAGE = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_strobe_t             strb,
  input  logic [PAGE_W+WORD_W-1:0] zAddr,
  input  logic [15:0]              wData,
  output logic                     rwwBusy,
  output logic                     cpuHalt,
  output logic                     bufWrEn,
  output logic [WORD_W-1:0]        bufWrAddr,
  output logic [15:0]              bufWrData,
  output logic                     bufClear
);
  localparam int ADDR_W = PAGE_W + WORD_W;

  logic [PAGE_W-1:0] pageSel;
  logic              inNrww;
  logic              opIsWrite;

  assign pageSel = zAddr[ADDR_W-1:WORD_W];
  assign inNrww  = ({1'b0, pageSel} >= (PAGE_W+1)'(NRWW_FIRST_PAGE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rwwBusy   <= 1'b0;
      cpuHalt   <= 1'b0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
      bufClear  <= 1'b0;
      opIsWrite <= 1'b0;
    end else begin
      bufWrEn  <= strb.loadWord;
      bufClear <= 1'b0;
      if (strb.loadWord) begin
        bufWrAddr <= zAddr[WORD_W-1:0];
        bufWrData <= wData;
      end
      if (strb.startOp) begin
        opIsWrite <= strb.isWrite;
        if (inNrww) cpuHalt <= 1'b1;
        else        rwwBusy <= 1'b1;
      end
      if (strb.opDone) begin
        cpuHalt  <= 1'b0;
        bufClear <= opIsWrite;
      end
      if (strb.reenable) begin
        rwwBusy  <= 1'b0;
        bufClear <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/selfprog_cmd_ctrl.sv
module selfprog_cmd_ctrl
  import selfprog_pkg::*;
#(
  parameter int PAGE_W          = 5,
  parameter int WORD_W          = 5,
  parameter int NRWW_FIRST_PAGE = 24,
  parameter int BUSY_CYCLES     = 20,
  parameter int ARM_WINDOW      = 4,
  localparam int ADDR_W         = PAGE_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic [7:0]        ctlWrData,
  input  logic              execStrobe,
  input  logic [ADDR_W-1:0] zAddr,
  input  logic [15:0]       wData,
  output logic [7:0]        ctlStatus,
  output logic              rwwBusy,
  output logic              cpuHalt,
  output logic              irqReq,
  output logic              bufWrEn,
  output logic [WORD_W-1:0] bufWrAddr,
  output logic [15:0]       bufWrData,
  output logic              bufClear
);
  ctrl_strobe_t strb;
  logic         pending;
  logic         irqEnable;
  logic [5:1]   cmdHi;

  selfprog_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .ARM_WINDOW(ARM_WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .execStrobe(execStrobe), .strb(strb), .pending(pending),
    .irqEnable(irqEnable), .cmdHi(cmdHi)
  );

  selfprog_dpath #(.PAGE_W(PAGE_W), .WORD_W(WORD_W), .NRWW_FIRST_PAGE(NRWW_FIRST_PAGE)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .zAddr(zAddr), .wData(wData),
    .rwwBusy(rwwBusy), .cpuHalt(cpuHalt), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .bufClear(bufClear)
  );

  assign ctlStatus = {irqEnable, rwwBusy, cmdHi, pending};
  assign irqReq    = irqEnable && !pending;
endmodule

// File: rtl/selfprog_checker.sv
module selfprog_checker (
  input logic       clk,
  input logic       rstN,
  input logic       ctlWrEn,
  input logic [7:0] ctlWrData,
  input logic       execStrobe,
  input logic [7:0] ctlStatus,
  input logic       rwwBusy,
  input logic       cpuHalt,
  input logic       irqReq,
  input logic       bufWrEn,
  input logic       bufClear
);
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |=> !bufWrEn); // R3
  AST_LOAD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $past(execStrobe)); // R3
  AST_HALT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuHalt) |-> $past(execStrobe)); // R7
  AST_HALT_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |-> ctlStatus[0]); // R7
  AST_REGION_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuHalt) |-> !$rose(rwwBusy)); // R6
  AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rwwBusy) |-> $past(ctlWrEn && ctlWrData[4])); // R8
  AST_BUSY_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rwwBusy) |-> bufClear); // R8
  AST_IRQ_ON_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctlStatus[0]) && ctlStatus[7]) |-> irqReq); // R9
endmodule

bind selfprog_cmd_ctrl selfprog_checker u_chk (.*);

// File: tb/test_selfprog_cmd_ctrl.sv
`timescale 1ns/1ps
module test_selfprog_cmd_ctrl;
  localparam int PAGE_W = 5;
  localparam int WORD_W = 5;
  localparam int NRWW_FIRST = 24;
  localparam int BUSY = 20;
  localparam int ADDR_W = PAGE_W + WORD_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic execStrobe = 1'b0;
  logic [ADDR_W-1:0] zAddr = '0;
  logic [15:0] wData = '0;
  logic [7:0] ctlStatus;
  logic rwwBusy, cpuHalt, irqReq, bufWrEn, bufClear;
  logic [WORD_W-1:0] bufWrAddr;
  logic [15:0] bufWrData;

  int nChecks = 0;
  int nFail = 0;
  int clearCount = 0;
  logic [WORD_W+15:0] expQ[$];

  always #5 clk = ~clk;

  selfprog_cmd_ctrl #(.PAGE_W(PAGE_W), .WORD_W(WORD_W), .NRWW_FIRST_PAGE(NRWW_FIRST),
                      .BUSY_CYCLES(BUSY), .ARM_WINDOW(4)) i_selfprog_cmd_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .execStrobe(execStrobe), .zAddr(zAddr), .wData(wData), .ctlStatus(ctlStatus),
    .rwwBusy(rwwBusy), .cpuHalt(cpuHalt), .irqReq(irqReq), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .bufClear(bufClear)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(int page, int word);
    return {PAGE_W'(page), WORD_W'(word)};
  endfunction

  task automatic ctlWrite(logic [7:0] v);
    ctlWrEn = 1'b1; ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0; ctlWrData = '0;
  endtask

  task automatic strobe(logic [ADDR_W-1:0] a, logic [15:0] d);
    execStrobe = 1'b1; zAddr = a; wData = d;
    @(negedge clk);
    execStrobe = 1'b0;
  endtask

  // driver: push the expected buffer write, then strobe
  task automatic loadWord(int page, int word, logic [15:0] d);
    expQ.push_back({WORD_W'(word), d});
    strobe(mkAddr(page, word), d);
  endtask

  // monitor: every buffer write must match the head of the queue (R3, R5)
  always @(negedge clk) begin
    if (rstN) begin
      if (bufWrEn) begin
        if (expQ.size() == 0) check("R5", 32'(bufWrAddr), 32'hFFFF, "unexpected buffer write");
        else begin
          logic [WORD_W+15:0] e;
          e = expQ.pop_front();
          check("R3", 32'({bufWrAddr, bufWrData}), 32'(e), "buffer write addr/data");
        end
      end
      if (bufClear) clearCount++;
    end
  end

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(ctlStatus), 0, "status after reset");
    check("R1", 32'({rwwBusy, cpuHalt, irqReq, bufWrEn, bufClear}), 0, "outputs after reset");

    // R3 load accepted on first edge
    ctlWrite(8'h01);
    check("R5", 32'(ctlStatus[0]), 1, "pending after arm");
    loadWord(3, 7, 16'hA55A);
    check("R3", 32'(ctlStatus[0]), 0, "pending cleared by load");

    // R5 load accepted on fourth edge
    ctlWrite(8'h01);
    repeat (3) @(negedge clk);
    loadWord(2, 9, 16'h1234);

    // R5 strobe on fifth edge discarded
    ctlWrite(8'h01);
    repeat (3) @(negedge clk);
    check("R5", 32'(ctlStatus[0]), 1, "pending before window end");
    @(negedge clk);
    check("R5", 32'(ctlStatus[0]), 0, "pending after window end");
    strobe(mkAddr(1, 1), 16'hDEAD);
    @(negedge clk);
    check("R5", 32'(expQ.size()), 0, "no load after window");

    // R10 write and strobe in same cycle: write wins, window restarts
    ctlWrite(8'h01);
    repeat (3) @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = 8'h01; execStrobe = 1'b1; zAddr = mkAddr(4, 4); wData = 16'hBEEF;
    @(negedge clk);
    ctlWrEn = 1'b0; ctlWrData = '0; execStrobe = 1'b0;
    check("R10", 32'(ctlStatus[0]), 1, "window reopened by write");
    repeat (3) @(negedge clk);
    loadWord(4, 5, 16'hCAFE);

    // R11 unknown code discarded
    ctlWrite(8'h09);
    strobe(mkAddr(6, 0), 16'h0);
    check("R11", 32'(ctlStatus[0]), 0, "pending cleared by unknown code");
    check("R11", 32'({rwwBusy, cpuHalt}), 0, "no operation for unknown code");

    // R2 R6 erase in read-while-write region, word bits and data ignored
    ctlWrite(8'h03);
    strobe(mkAddr(5, 3), 16'hFFFF);
    check("R6", 32'({rwwBusy, cpuHalt}), 32'b10, "rww erase busy, no halt");
    check("R2", 32'(ctlStatus), 32'h43, "status during erase");
    ctlWrite(8'h01); // R10 ignored while busy
    repeat (BUSY - 2) @(negedge clk);
    check("R10", 32'(ctlStatus), 32'h43, "write during op ignored");
    @(negedge clk);
    check("R2", 32'(ctlStatus[0]), 0, "pending cleared at erase end");
    strobe(mkAddr(5, 1), 16'h5555);
    repeat (3) @(negedge clk);
    check("R8", 32'(rwwBusy), 1, "busy sticky after erase");
    check("R9", 32'(irqReq), 0, "no irq while disabled");
    check("R8", 32'(clearCount), 0, "no buffer clear after erase");

    // R8 re-enable with interrupt enable set
    ctlWrite(8'h90);
    @(negedge clk);
    check("R8", 32'(rwwBusy), 0, "busy cleared by re-enable");
    check("R8", 32'(clearCount), 1, "buffer cleared by re-enable");
    check("R9", 32'(irqReq), 1, "irq with enable and nothing pending");

    // R4 R7 page write in halting region
    ctlWrite(8'h85);
    check("R9", 32'(irqReq), 0, "irq low while pending");
    strobe(mkAddr(30, 0), 16'h0);
    n = 0;
    while (cpuHalt && n < 1000) begin n++; @(negedge clk); end
    check("R7", 32'(n), 32'(BUSY), "halt length");
    check("R7", 32'(ctlStatus[0]), 0, "pending cleared with halt");
    check("R6", 32'(rwwBusy), 0, "no busy flag for halting region");
    check("R9", 32'(irqReq), 1, "irq after completion");
    @(negedge clk);
    check("R4", 32'(clearCount), 2, "buffer cleared after page write");
    check("R3", 32'(expQ.size()), 0, "all expected loads seen");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule